// File: doc/BRIEF.md
# Asynchronous Schedule Park-Mode Iterator

This block sits beside the traversal engine of a USB host controller's asynchronous schedule. It sets how many consecutive bus transactions the engine may run from the queue head it has just loaded. After each transaction the block tells the engine either to stay on that queue head for one more transaction or to move on to the next one. One global policy covers every high-speed queue head: a park enable and a small repeat count. Queue heads that serve low- or full-speed endpoints always get a single transaction per pass. The periodic schedule never goes through this block.

The park enable and repeat count are held in a small register slice that software can write. It takes writes only when a capability strap is tied high. With the strap low, both fields are fixed at zero. The engine pulses `qh_load` each time it fetches a new queue head, and it pulses `txn_done` with the result flags when a transaction finishes. One cycle later the block pulses exactly one of `stay` or `advance`.

Top module: `park_iter`

## Requirements
- R1: After reset, `stay` and `advance` are 0 and `park_en_rd` is 0. `park_cnt_rd` is 3 when `park_cap` is 1 and 0 when it is 0.
- R2: While `park_cap` is 0, `cfg_we` has no effect. The readback stays at enable 0 and count 0, and each queue head gets one transaction.
- R3: While `park_cap` is 1, `cfg_we` loads `cfg_park_en` and `cfg_park_cnt`, and they show on the readback ports the next cycle.
- R4: With park disabled, a high-speed queue head gets one transaction. The first `txn_done` gives `advance`.
- R5: With park enabled and count N (1 to 3), a high-speed queue head gets N transactions: N-1 `stay` pulses, then `advance`.
- R6: A park count of 0 is treated as 1.
- R7: A queue head with `qh_hs` = 0 (low or full speed) always gets `advance` after its first transaction, whatever the park settings.
- R8: A transaction that reports `res_nak`, `res_short`, `res_halt` or `res_qtd_done` gives `advance` at once, even if budget remains.
- R9: `qh_load` reloads the budget from the current settings and drops any budget left from the previous queue head. If `qh_load` and `txn_done` arrive in the same cycle, the load wins and the `txn_done` is ignored.
- R10: `stay` and `advance` are never high together. One of them pulses exactly one cycle after a `txn_done` that arrives while a queue head is loaded. A `txn_done` that arrives with no queue head loaded (after `advance`, or before any load) gives neither.
- R11: The budget is fixed when `qh_load` arrives. A configuration write in the same cycle as `qh_load`, or while the queue head is being served, affects only later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| park_cap | input | 1 | Capability strap; 1 makes the park fields writable |
| cfg_we | input | 1 | Write strobe for the park fields |
| cfg_park_en | input | 1 | Park enable write data |
| cfg_park_cnt | input | CNT_W | Park count write data |
| park_en_rd | output | 1 | Current park enable |
| park_cnt_rd | output | CNT_W | Current park count |
| qh_load | input | 1 | Pulse: traversal loaded a new queue head |
| qh_hs | input | 1 | Loaded queue head is high speed (valid with `qh_load`) |
| txn_done | input | 1 | Pulse: a bus transaction on the current queue head finished |
| res_nak | input | 1 | Finished transaction was NAKed |
| res_short | input | 1 | Finished transaction moved a short packet |
| res_halt | input | 1 | Finished transaction halted the queue head |
| res_qtd_done | input | 1 | Finished transaction completed its transfer descriptor |
| stay | output | 1 | Pulse: run another transaction on this queue head |
| advance | output | 1 | Pulse: move on to the next queue head |

## Verification
A wrong remaining-budget count first shows up as one `stay` too many or one `stay` too few, on the `txn_done` where the real budget runs out. A stale active flag shows up as a decision pulse after a `txn_done` that should have been ignored. Either fault is visible one cycle after the transaction that exposes it. A configuration register that accepts writes when it should not is visible on the readback one cycle after the write, and at the next queue head load it also changes how many transactions that queue head gets. The bench compares every output to a behavioural model on every cycle, so any such fault is reported within one cycle.

// File: rtl/park_iter.sv
module park_iter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park_cap,
  input  logic             cfg_we,
  input  logic             cfg_park_en,
  input  logic [CNT_W-1:0] cfg_park_cnt,
  output logic             park_en_rd,
  output logic [CNT_W-1:0] park_cnt_rd,
  input  logic             qh_load,
  input  logic             qh_hs,
  input  logic             txn_done,
  input  logic             res_nak,
  input  logic             res_short,
  input  logic             res_halt,
  input  logic             res_qtd_done,
  output logic             stay,
  output logic             advance
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] left_q;
  logic             active_q;
  logic             stay_q, adv_q;

  logic [CNT_W-1:0] cnt_eff, budget;
  logic             early, take, last;

  assign cnt_eff = (cnt_q == '0) ? CNT_ONE : cnt_q;
  assign budget  = (en_q && qh_hs) ? cnt_eff : CNT_ONE;
  assign early   = res_nak | res_short | res_halt | res_qtd_done;
  assign take    = txn_done && active_q && !qh_load;
  assign last    = early || (left_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cnt_q    <= park_cap ? CNT_MAX : '0;
      left_q   <= '0;
      active_q <= 1'b0;
      stay_q   <= 1'b0;
      adv_q    <= 1'b0;
    end else begin
      stay_q <= 1'b0;
      adv_q  <= 1'b0;
      if (cfg_we && park_cap) begin
        en_q  <= cfg_park_en;
        cnt_q <= cfg_park_cnt;
      end
      if (qh_load) begin
        active_q <= 1'b1;
        left_q   <= budget;
      end else if (take) begin
        if (last) begin
          adv_q    <= 1'b1;
          active_q <= 1'b0;
          left_q   <= '0;
        end else begin
          stay_q <= 1'b1;
          left_q <= left_q - CNT_ONE;
        end
      end
    end
  end

  assign stay        = stay_q;
  assign advance     = adv_q;
  assign park_en_rd  = en_q;
  assign park_cnt_rd = cnt_q;

  AST_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({stay, advance})); // R10
  AST_CAUSED:     assert property (@(posedge clk) disable iff (!rst_n) (stay || advance) |-> $past(txn_done && !qh_load)); // R10
  AST_FIXED_CFG:  assert property (@(posedge clk) disable iff (!rst_n) !park_cap |=> (park_en_rd == 1'b0 && park_cnt_rd == '0)); // R2
  AST_LSFS_ONE:   assert property (@(posedge clk) disable iff (!rst_n) (qh_load && !qh_hs) |=> left_q == CNT_ONE); // R7
  AST_BUDGET_NZ:  assert property (@(posedge clk) disable iff (!rst_n) active_q |-> left_q != '0); // R6
  AST_EARLY_END:  assert property (@(posedge clk) disable iff (!rst_n) (txn_done && active_q && !qh_load && early) |=> advance); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (txn_done && !active_q && !qh_load) |=> !(stay || advance)); // R10
endmodule

// File: tb/test_park_iter.sv
`timescale 1ns/1ps
module test_park_iter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic park_cap = 1'b1;
  logic cfg_we = 1'b0, cfg_park_en = 1'b0;
  logic [1:0] cfg_park_cnt = 2'd0;
  logic park_en_rd;
  logic [1:0] park_cnt_rd;
  logic qh_load = 1'b0, qh_hs = 1'b0, txn_done = 1'b0;
  logic res_nak = 1'b0, res_short = 1'b0, res_halt = 1'b0, res_qtd_done = 1'b0;
  logic stay, advance;

  int tests = 0, fails = 0;
  string req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  park_iter #(.CNT_W(2)) i_park_iter (
    .clk(clk), .rst_n(rst_n), .park_cap(park_cap), .cfg_we(cfg_we),
    .cfg_park_en(cfg_park_en), .cfg_park_cnt(cfg_park_cnt),
    .park_en_rd(park_en_rd), .park_cnt_rd(park_cnt_rd),
    .qh_load(qh_load), .qh_hs(qh_hs), .txn_done(txn_done),
    .res_nak(res_nak), .res_short(res_short), .res_halt(res_halt),
    .res_qtd_done(res_qtd_done), .stay(stay), .advance(advance));

  int m_en, m_cnt, m_left, m_act, e_stay, e_adv;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cnt = park_cap ? 3 : 0; m_left = 0; m_act = 0; e_stay = 0; e_adv = 0;
    end else begin
      e_stay = 0; e_adv = 0;
      if (qh_load) begin
        m_act = 1;
        m_left = (m_en != 0 && qh_hs) ? ((m_cnt == 0) ? 1 : m_cnt) : 1;
      end else if (txn_done && m_act != 0) begin
        if (res_nak || res_short || res_halt || res_qtd_done || m_left == 1) begin
          e_adv = 1; m_act = 0;
        end else begin
          e_stay = 1; m_left = m_left - 1;
        end
      end
      if (cfg_we && park_cap) begin m_en = cfg_park_en; m_cnt = cfg_park_cnt; end
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(req, "stay", stay, e_stay);
    chk(req, "advance", advance, e_adv);
    chk(req, "park_en_rd", park_en_rd, m_en);
    chk(req, "park_cnt_rd", park_cnt_rd, m_cnt);
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(bit en, int cnt);
    @(negedge clk); cfg_we = 1; cfg_park_en = en; cfg_park_cnt = 2'(cnt);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic load(bit hs);
    @(negedge clk); qh_load = 1; qh_hs = hs;
    @(negedge clk); qh_load = 0;
  endtask
  task automatic txn(bit n, bit s, bit h, bit q);
    @(negedge clk); txn_done = 1; res_nak = n; res_short = s; res_halt = h; res_qtd_done = q;
    @(negedge clk); txn_done = 0; res_nak = 0; res_short = 0; res_halt = 0; res_qtd_done = 0;
  endtask
  task automatic do_reset(bit cap);
    @(negedge clk); rst_n = 0; park_cap = cap;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    req = "R1";
    chk("R1", "reset stay", stay, 0);
    chk("R1", "reset advance", advance, 0);
    chk("R1", "reset en", park_en_rd, 0);
    chk("R1", "reset cnt cap=1", park_cnt_rd, 3);

    req = "R3"; wr(0, 2); tick();
    chk("R3", "cnt readback", park_cnt_rd, 2);
    req = "R4"; load(1); txn(0,0,0,0); tick(); txn(0,0,0,0); tick();
    req = "R10"; txn(0,0,0,0); tick();
    req = "R5";
    for (int n = 1; n <= 3; n++) begin
      wr(1, n); load(1);
      for (int k = 0; k < n; k++) begin txn(0,0,0,0); tick(); end
    end
    chk("R3", "en readback", park_en_rd, 1);
    req = "R6"; wr(1, 0); load(1); txn(0,0,0,0); txn(0,0,0,0); tick();
    req = "R7"; wr(1, 3); load(0); txn(0,0,0,0); txn(0,0,0,0); tick();
    req = "R8";
    for (int t = 0; t < 4; t++) begin
      load(1); txn(0,0,0,0); txn(t==0, t==1, t==2, t==3); txn(0,0,0,0); tick();
    end
    req = "R9"; load(1); txn(0,0,0,0); load(1); txn(0,0,0,0); txn(0,0,0,0); txn(0,0,0,0); tick();
    @(negedge clk); qh_load = 1; qh_hs = 1; txn_done = 1;
    @(negedge clk); qh_load = 0; txn_done = 0;
    txn(0,0,0,0); txn(0,0,0,0); txn(0,0,0,0); tick();
    req = "R11"; load(1); wr(1, 1); txn(0,0,0,0); txn(0,0,0,0); txn(0,0,0,0); tick();
    @(negedge clk); qh_load = 1; qh_hs = 1; cfg_we = 1; cfg_park_en = 1; cfg_park_cnt = 2'd3;
    @(negedge clk); qh_load = 0; cfg_we = 0;
    txn(0,0,0,0); txn(0,0,0,0); tick();

    req = "R1"; do_reset(0);
    chk("R1", "reset cnt cap=0", park_cnt_rd, 0);
    req = "R2"; wr(1, 3); tick();
    chk("R2", "en stays 0", park_en_rd, 0);
    chk("R2", "cnt stays 0", park_cnt_rd, 0);
    load(1); txn(0,0,0,0); txn(0,0,0,0); tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule